// File: doc/BRIEF.md
# Unsigned Counter-Tree Multiplier

This block multiplies two unsigned N-bit operands in a single combinational path and delivers the full 2N-bit product. Every bit pair a[i]·b[j] becomes one dot in product column i+j. The resulting column heights are reduced in a fixed number of stages, and each stage works against a preset height ceiling. The ceilings start at the final row count K and double from one stage to the next, because a counter with six inputs and three outputs cuts a column by a factor of two. The first stage aims at the largest ceiling that is still below the tallest column.

Within a stage, columns are visited from the least significant upward. The height a column must meet includes the carries that counters in the two columns below it have already pushed in. Each counter is a single-column population counter of two to six inputs. It is sized to remove exactly the remaining excess, and six-input counters are used while the excess is large. A counter takes the column's own stage-input dots first, because they settle earliest. It reaches into same-stage carries only when its own dots run out. When the last stage is done, at most K rows remain, and a carry-propagate adder sums them.

K = 3 pairs the tree with a three-operand final adder, and K = 2 pairs it with an ordinary two-operand adder. Sign handling, operand recoding and pipeline registers are not part of the block. Carries that would land at or above bit 2N are discarded, which cannot change an unsigned product that fits in 2N bits.

Top module: `ctr_mult`

## Requirements
- R1: For every pair of unsigned operands, p equals a·b exactly over all 2N bits, with the default build (N = 16, K = 3, ternary final adder).
- R2: If either operand is zero, every product bit is zero.
- R3: The product never wraps. All-ones times all-ones yields 2^(2N) − 2^(N+1) + 1 (0xFFFE0001 for N = 16), and any two nonzero operands give a product no smaller than either operand.
- R4: For a = 2^i and b = 2^j, the product has bit i+j set and no other bit set.
- R5: If b = 1 the product equals a, and if a = 1 it equals b.
- R6: Swapping the operands leaves the product unchanged.
- R7: The build with K = 2 gives exact products for the same operand set. In that build the reduction ends at two rows and feeds a binary final adder.
- R8: Widths other than 16 give exact products for every operand pair. The cases covered are N = 7 with K = 2 and N = 6 with K = 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | Unsigned multiplicand |
| b_i | input | N | Unsigned multiplier |
| p_o | output | 2N | Unsigned product a_i·b_i |

## Verification
Suppose a counter is given the wrong input slice, or a carry is routed to the wrong column. The product is then off by a signed power of two, equal to the weight of the column where the misplaced dot landed. Because the path is purely combinational, the error appears within the same cycle as the operands. Single-bit operands light exactly one dot, so each column's routing is examined in isolation. All-ones operands fill the tallest columns and push the largest counters and the longest carry runs. Exhaustive runs at small widths cover every stage plan those widths produce.

// File: rtl/ctr_mult_pkg.sv
package ctr_mult_pkg;

    localparam int CNT_MAX_IN = 6;
    localparam int CNT_OUT_W  = 3;
    localparam int LIMIT_GROWTH = CNT_MAX_IN / CNT_OUT_W;

    typedef struct packed {
        logic s2;
        logic s1;
        logic s0;
    } cnt_sum_t;

    typedef enum logic [2:0] {
        PQ_OWN,
        PQ_FROM_BELOW1,
        PQ_CARRY_IN,
        PQ_EXCESS,
        PQ_HEIGHT_OUT
    } plan_q_e;

    // Height ceiling of the stage j-th from the end (j = 1 is the final stage).
    function automatic int stage_limit(int k, int j);
        int v;
        v = k;
        for (int i = 1; i < j; i++) v = v * LIMIT_GROWTH;
        return v;
    endfunction

    function automatic int num_stages(int tallest, int k);
        int j;
        j = 0;
        while (stage_limit(k, j + 1) < tallest) j++;
        return j;
    endfunction

    // Number of partial-product dots in column c of an n-by-n product.
    function automatic int pp_height(int n, int c);
        int lo, hi;
        lo = (c > n - 1) ? c - n + 1 : 0;
        hi = (c < n - 1) ? c : n - 1;
        return (hi >= lo) ? hi - lo + 1 : 0;
    endfunction

    // Input count of counter q when a column must shed e dots.
    function automatic int cnt_size(int e, int q);
        int r, s;
        r = e;
        for (int i = 0; i < q; i++) begin
            s = (r + 1 < CNT_MAX_IN) ? r + 1 : CNT_MAX_IN;
            r = r - (s - 1);
        end
        return (r + 1 < CNT_MAX_IN) ? r + 1 : CNT_MAX_IN;
    endfunction

    function automatic int cnt_count(int e);
        int r, q;
        r = e;
        q = 0;
        while (r > 0) begin
            r = r - (cnt_size(r, 0) - 1);
            q++;
        end
        return q;
    endfunction

    // Counters wide enough to drive a third output bit (four inputs or more).
    function automatic int cnt_wide(int e);
        int w;
        w = 0;
        for (int q = 0; q < cnt_count(e); q++)
            if (cnt_size(e, q) >= 4) w++;
        return w;
    endfunction

    function automatic int cnt_start(int e, int q);
        int s;
        s = 0;
        for (int i = 0; i < q; i++) s = s + cnt_size(e, i);
        return s;
    endfunction

endpackage

// File: rtl/ctr_popcount.sv
module ctr_popcount
    import ctr_mult_pkg::*;
#(
    parameter int WIDTH = 6
) (
    input  logic [WIDTH-1:0] dots_i,
    output cnt_sum_t         sum_o
);

    logic [CNT_OUT_W-1:0] acc;

    always_comb begin
        acc = '0;
        for (int i = 0; i < WIDTH; i++)
            acc = acc + {{(CNT_OUT_W-1){1'b0}}, dots_i[i]};
        sum_o = acc;
    end

endmodule

// File: rtl/ctr_reduce_stage.sv
module ctr_reduce_stage
    import ctr_mult_pkg::*;
#(
    parameter int N     = 16,
    parameter int K     = 3,
    parameter int STAGE = 0
) (
    input  logic [2*N-1:0][N-1:0] dots_i,
    output logic [2*N-1:0][N-1:0] dots_o
);

    localparam int W    = 2 * N;
    localparam int NSTG = num_stages(N, K);
    localparam int PMAX = 2 * N + 8;
    localparam int QMAX = PMAX / (CNT_MAX_IN - 1) + 1;

    // Replays the column plan from the raw partial products up to this stage.
    function automatic int plan(int col, plan_q_e what);
        int h  [W];
        int hn [W];
        int e  [W];
        int inc1, inc, lim, res;
        res = 0;
        for (int c = 0; c < W; c++) h[c] = pp_height(N, c);
        for (int t = 0; t <= STAGE; t++) begin
            lim = stage_limit(K, NSTG - t);
            for (int c = 0; c < W; c++) begin
                inc1 = (c >= 1) ? cnt_count(e[c-1]) : 0;
                inc  = inc1 + ((c >= 2) ? cnt_wide(e[c-2]) : 0);
                e[c] = h[c] + inc - lim;
                hn[c] = (e[c] > 0) ? lim : h[c] + inc;
                if (t == STAGE && c == col) begin
                    case (what)
                        PQ_OWN:         res = h[c];
                        PQ_FROM_BELOW1: res = inc1;
                        PQ_CARRY_IN:    res = inc;
                        PQ_EXCESS:      res = e[c];
                        default:        res = hn[c];
                    endcase
                end
            end
            h = hn;
        end
        return res;
    endfunction

    logic [W-1:0][PMAX-1:0]  pool;
    cnt_sum_t [QMAX-1:0]     sums [W];

    for (genvar c = 0; c < W; c++) begin : g_col
        localparam int H     = plan(c, PQ_OWN);
        localparam int I1    = plan(c, PQ_FROM_BELOW1);
        localparam int INC   = plan(c, PQ_CARRY_IN);
        localparam int E     = plan(c, PQ_EXCESS);
        localparam int HOUT  = plan(c, PQ_HEIGHT_OUT);
        localparam int NQ    = cnt_count(E);
        localparam int TAKEN = cnt_start(E, NQ);

        // Pool order: own dots, carries from c-1, carries from c-2, own sums.
        for (genvar p = 0; p < PMAX; p++) begin : g_pos
            if (p < H) begin : g_own
                assign pool[c][p] = dots_i[c][p];
            end else if (p < H + I1) begin : g_c1
                assign pool[c][p] = sums[c-1][p-H].s1;
            end else if (p < H + INC) begin : g_c2
                assign pool[c][p] = sums[c-2][p-H-I1].s2;
            end else if (p < H + INC + NQ) begin : g_self
                assign pool[c][p] = sums[c][p-H-INC].s0;
            end else begin : g_nil
                assign pool[c][p] = 1'b0;
            end
        end

        for (genvar q = 0; q < QMAX; q++) begin : g_cnt
            if (q < NQ) begin : g_use
                localparam int SZ = cnt_size(E, q);
                localparam int ST = cnt_start(E, q);
                ctr_popcount #(.WIDTH(SZ)) u_cnt (
                    .dots_i (pool[c][ST +: SZ]),
                    .sum_o  (sums[c][q])
                );
            end else begin : g_off
                assign sums[c][q] = '0;
            end
        end

        for (genvar r = 0; r < N; r++) begin : g_out
            if (r < HOUT) begin : g_keep
                assign dots_o[c][r] = pool[c][TAKEN + r];
            end else begin : g_zero
                assign dots_o[c][r] = 1'b0;
            end
        end

        logic unused_col;
        assign unused_col = ^{sums[c], pool[c], dots_i[c]};
    end

endmodule

// File: rtl/ctr_row_adder.sv
module ctr_row_adder #(
    parameter int W = 32,
    parameter int K = 3
) (
    input  logic [K-1:0][W-1:0] rows_i,
    output logic [W-1:0]        sum_o
);

    always_comb begin
        sum_o = '0;
        for (int r = 0; r < K; r++)
            sum_o = sum_o + rows_i[r];
    end

endmodule

// File: rtl/ctr_mult.sv
module ctr_mult
    import ctr_mult_pkg::*;
#(
    parameter int N = 16,
    parameter int K = 3
) (
    input  logic [N-1:0]   a_i,
    input  logic [N-1:0]   b_i,
    output logic [2*N-1:0] p_o
);

    localparam int W    = 2 * N;
    localparam int NSTG = num_stages(N, K);

    logic [W-1:0][N-1:0] lvl [NSTG+1];
    logic [K-1:0][W-1:0] rows;

    // Partial-product dots: column c holds a[lo+p] & b[c-lo-p].
    for (genvar c = 0; c < W; c++) begin : g_pp_col
        localparam int LO = (c > N - 1) ? c - N + 1 : 0;
        localparam int H  = pp_height(N, c);
        for (genvar p = 0; p < N; p++) begin : g_pp_dot
            if (p < H) begin : g_dot
                assign lvl[0][c][p] = a_i[LO+p] & b_i[c-LO-p];
            end else begin : g_nil
                assign lvl[0][c][p] = 1'b0;
            end
        end
    end

    for (genvar s = 0; s < NSTG; s++) begin : g_stage
        ctr_reduce_stage #(.N(N), .K(K), .STAGE(s)) u_stage (
            .dots_i (lvl[s]),
            .dots_o (lvl[s+1])
        );
    end

    for (genvar r = 0; r < K; r++) begin : g_row
        for (genvar c = 0; c < W; c++) begin : g_bit
            assign rows[r][c] = lvl[NSTG][c][r];
        end
    end

    ctr_row_adder #(.W(W), .K(K)) u_add (
        .rows_i (rows),
        .sum_o  (p_o)
    );

    logic unused_rows;
    assign unused_rows = ^lvl[NSTG];

endmodule

// File: rtl/ctr_mult_chk.sv
module ctr_mult_chk #(
    parameter int N = 16
) (
    input logic [N-1:0]   a_i,
    input logic [N-1:0]   b_i,
    input logic [2*N-1:0] p_o
);

    logic [2*N-1:0] a_w, b_w;
    assign a_w = {{N{1'b0}}, a_i};
    assign b_w = {{N{1'b0}}, b_i};

    always_comb begin
        AST_EXACT_PRODUCT: assert (p_o == a_w * b_w);                      // R1
        if (a_i == '0 || b_i == '0)
            AST_ZERO_ABSORBS: assert (p_o == '0);                          // R2
        if (a_i != '0 && b_i != '0)
            AST_NO_WRAP: assert (p_o >= a_w && p_o >= b_w);                // R3
        AST_LSB_DOT: assert (p_o[0] == (a_i[0] & b_i[0]));                 // R4
        if (b_i == {{(N-1){1'b0}}, 1'b1})
            AST_UNIT_IDENTITY: assert (p_o == a_w);                        // R5
    end

endmodule

bind ctr_mult ctr_mult_chk #(.N(N)) u_chk (
    .a_i (a_i),
    .b_i (b_i),
    .p_o (p_o)
);

// File: tb/ctr_mult_bench.sv
module ctr_mult_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [15:0] a, b;
    logic [31:0] p3, p2;
    logic [6:0]  a7, b7;
    logic [13:0] p7;
    logic [5:0]  a6, b6;
    logic [11:0] p6;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    ctr_mult #(.N(16), .K(3)) u_ctr_mult (.a_i(a),  .b_i(b),  .p_o(p3));
    ctr_mult #(.N(16), .K(2)) u_ctr_k2   (.a_i(a),  .b_i(b),  .p_o(p2));
    ctr_mult #(.N(7),  .K(2)) u_ctr_n7   (.a_i(a7), .b_i(b7), .p_o(p7));
    ctr_mult #(.N(6),  .K(3)) u_ctr_n6   (.a_i(a6), .b_i(b6), .p_o(p6));

    task automatic check(input logic [31:0] got, input logic [31:0] exp, input string req);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Drive both 16-bit builds, sample mid-cycle, compare (K=2 result under R7).
    task automatic apply16(input logic [15:0] x, input logic [15:0] y,
                           input logic [31:0] exp, input string req);
        @(posedge clk);
        a = x;
        b = y;
        @(negedge clk);
        check(p3, exp, req);
        check(p2, exp, "R7");
    endtask

    task automatic t_reset;
        a = '0; b = '0; a7 = '0; b7 = '0; a6 = '0; b6 = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(p3, 32'h0, "R2 reset");
        check(p2, 32'h0, "R2 reset");
        check({18'h0, p7}, 32'h0, "R2 reset");
        check({20'h0, p6}, 32'h0, "R2 reset");
    endtask

    task automatic t_zero;
        apply16(16'h0, 16'hFFFF, 32'h0, "R2");
        apply16(16'hFFFF, 16'h0, 32'h0, "R2");
        for (int i = 0; i < 20; i++) begin
            logic [15:0] x;
            x = 16'($urandom);
            apply16(x, 16'h0, 32'h0, "R2");
            apply16(16'h0, x, 32'h0, "R2");
        end
    endtask

    task automatic t_all_ones;
        apply16(16'hFFFF, 16'hFFFF, 32'hFFFE0001, "R3");
        apply16(16'hFFFF, 16'h8000, 32'h7FFF8000, "R3");
        apply16(16'h7FFF, 16'hFFFF, 32'h7FFE8001, "R3");
    endtask

    task automatic t_single_bits;
        for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++)
                apply16(16'(1) << i, 16'(1) << j, 32'(1) << (i + j), "R4");
    endtask

    task automatic t_identity;
        for (int i = 0; i < 20; i++) begin
            logic [15:0] x;
            x = 16'($urandom);
            apply16(x, 16'h1, {16'h0, x}, "R5");
            apply16(16'h1, x, {16'h0, x}, "R5");
        end
        apply16(16'hFFFF, 16'h1, 32'h0000FFFF, "R5");
    endtask

    task automatic t_swap;
        for (int i = 0; i < 50; i++) begin
            logic [15:0] x, y;
            logic [31:0] first;
            x = 16'($urandom);
            y = 16'($urandom);
            apply16(x, y, {16'h0, x} * {16'h0, y}, "R6");
            first = p3;
            apply16(y, x, {16'h0, x} * {16'h0, y}, "R6");
            check(p3, first, "R6 swap");
        end
    endtask

    task automatic t_random;
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] x, y;
            x = 16'($urandom);
            y = 16'($urandom);
            if (i % 4 == 1) x = x | 16'hF000;
            if (i % 4 == 2) y = y | 16'hFF00;
            apply16(x, y, {16'h0, x} * {16'h0, y}, "R1");
        end
    endtask

    task automatic t_small_widths;
        for (int x = 0; x < 128; x++)
            for (int y = 0; y < 128; y++) begin
                @(posedge clk);
                a7 = 7'(x);
                b7 = 7'(y);
                @(negedge clk);
                check({18'h0, p7}, 32'(x * y), "R8 N7");
            end
        for (int x = 0; x < 64; x++)
            for (int y = 0; y < 64; y++) begin
                @(posedge clk);
                a6 = 6'(x);
                b6 = 6'(y);
                @(negedge clk);
                check({20'h0, p6}, 32'(x * y), "R8 N6");
            end
    endtask

    initial begin
        t_reset();
        t_zero();
        t_all_ones();
        t_single_bits();
        t_identity();
        t_swap();
        t_random();
        t_small_widths();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule